// File: doc/BRIEF.md
# Timed Power-Rail Sequencer

This block turns on six board power rails in three timed groups after power-on. The converters give no separate power-good signal, so each group is held for a fixed delay before the next one is enabled. The delay is set by a counter whose length comes from the clock frequency and the stage time in milliseconds. A rail that has been enabled stays enabled in later stages. After the third stage the block enters a ready state.

In the ready state the block watches one combined power-good input. If that input goes low, every rail enable is removed and the block locks into a fault state. Only a power-on reset clears the fault. The block also drives an active-low reset toward the main device, a module power-good flag and a status line that follows the push-button reset. Both asynchronous inputs pass through two-flop synchronizers.

Rail enable bit positions are fixed: bit 0 = 1.8 V, bit 1 = 1.1 V memory rail, bit 2 = 2.5 V, bit 3 = 3.3 V, bit 4 = 1.0 V core, bit 5 = 2.5 V transceiver rail. The stage length is N = (CLK_HZ/1000)*STAGE_MS clock cycles.

Top module: `pwr_seq_top`

## Requirements
- R1: While `por_n` is low, `rail_en` is 0, and `mod_pgood` and `dev_rst_n` are low. On the first rising edge after `por_n` is released, `rail_en` becomes 6'h01.
- R2: Stage one lasts exactly N cycles with `rail_en` = 6'h01 (1.8 V only).
- R3: Stage two lasts exactly N cycles with `rail_en` = 6'h0F (1.8 V, 1.1 V, 2.5 V and 3.3 V).
- R4: Stage three lasts exactly N cycles with `rail_en` = 6'h3F (all six rails), and then the block enters ready.
- R5: No rail enable is removed before a fault. The set of enabled rails only grows.
- R6: In ready, `rail_en` = 6'h3F and `mod_pgood` is high. `mod_pgood` is low in every other state.
- R7: While ready, a low level on `pg_all_in` that is sampled at a rising edge moves the block to fault two edges later. In fault, `rail_en` = 0 and `mod_pgood` and `dev_rst_n` are low.
- R8: Fault is terminal. Restoring `pg_all_in` has no effect, and the outputs stay as in R7 until the next `por_n`.
- R9: `pg_all_in` is ignored before ready. A low level or toggling during stages one to three does not change the stage timing or the enables.
- R10: `noseq` equals `btn_rst_n` delayed by two rising edges through the synchronizer. It is low during `por_n`.
- R11: `dev_rst_n` stays low until ready. In ready it equals the synchronized `btn_rst_n` (two edges of delay), and it is low again in fault.
- R12: The stage length N is derived from `CLK_HZ` and `STAGE_MS`. With CLK_HZ = 20000 and STAGE_MS = 1, stage two begins on edge N+1 = 21 after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pg_all_in | input | 1 | Combined power-good from all converters (asynchronous) |
| btn_rst_n | input | 1 | Active-low push-button reset (asynchronous) |
| rail_en | output | 6 | Rail enables; bit positions as listed above |
| mod_pgood | output | 1 | High only in the ready state |
| dev_rst_n | output | 1 | Active-low reset toward the main device |
| noseq | output | 1 | Synchronized copy of the push-button reset |

## Verification
Each of several power-on runs uses a different power-good pattern during the three stages: held low, held high or randomly toggled. Matching stage boundaries across these runs show that power-good is ignored before ready and that the timing comes only from the counters. In ready, the push button is toggled at random and power-good is held high for a random length before it drops. This separates the pass-through of the reset output from its hold-off, and it checks the two-edge fault latency. After each fault, power-good is raised again to show that the lockout holds, and a new `por_n` must restart the sequence from stage one.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int NUM_RAILS  = 6;
    localparam int NUM_STAGES = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STG1  = 3'd1,
        ST_STG2  = 3'd2,
        ST_STG3  = 3'd3,
        ST_READY = 3'd4,
        ST_FAULT = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } fsm_regs_t;

    // Rails newly switched on by each stage (bit positions fixed by board wiring)
    localparam logic [NUM_RAILS-1:0] STG1_NEW = 6'b00_0001; // 1.8 V
    localparam logic [NUM_RAILS-1:0] STG2_NEW = 6'b00_1110; // 1.1 V, 2.5 V, 3.3 V
    localparam logic [NUM_RAILS-1:0] STG3_NEW = 6'b11_0000; // 1.0 V, 2.5 V xcvr

    function automatic logic [NUM_RAILS-1:0] rails_of(seq_state_e s);
        logic [NUM_RAILS-1:0] r;
        case (s)
            ST_STG1:  r = STG1_NEW;
            ST_STG2:  r = STG1_NEW | STG2_NEW;
            ST_STG3,
            ST_READY: r = STG1_NEW | STG2_NEW | STG3_NEW;
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic seq_state_e stage_state(int idx);
        seq_state_e s;
        case (idx)
            0:       s = ST_STG1;
            1:       s = ST_STG2;
            default: s = ST_STG3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwr_sync2.sv
module pwr_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {2{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[1];
endmodule

// File: rtl/pwr_stage_timer.sv
module pwr_stage_timer #(
    parameter int CYCLES = 35_000_000,
    localparam int CW    = (CYCLES > 2) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
        done  = run && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R12
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R12
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pg_ok,
    input  logic [NUM_STAGES-1:0] stage_done,
    output logic [NUM_STAGES-1:0] stage_run,
    output seq_state_e            state
);
    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_IDLE:  regs_d.state = ST_STG1;
            ST_STG1:  if (stage_done[0]) regs_d.state = ST_STG2;
            ST_STG2:  if (stage_done[1]) regs_d.state = ST_STG3;
            ST_STG3:  if (stage_done[2]) regs_d.state = ST_READY;
            ST_READY: if (!pg_ok)        regs_d.state = ST_FAULT;
            ST_FAULT: regs_d.state = ST_FAULT;
            default:  regs_d.state = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: ST_IDLE};
        else        regs_q <= regs_d;
    end

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_run
        assign stage_run[g] = (regs_q.state == stage_state(g));
    end

    assign state = regs_q.state;

    // R1
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_IDLE) |=> (regs_q.state == ST_STG1));

    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_READY && !pg_ok) |=> (regs_q.state == ST_FAULT));

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_FAULT) |=> (regs_q.state == ST_FAULT));

    // R9
    early_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state inside {ST_STG1, ST_STG2, ST_STG3}) |=> (regs_q.state != ST_FAULT));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int STAGE_MS = 700
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 pg_all_in,
    input  logic                 btn_rst_n,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 mod_pgood,
    output logic                 dev_rst_n,
    output logic                 noseq
);
    localparam int STAGE_CYCLES = (CLK_HZ / 1000) * STAGE_MS;

    logic                  pg_s, btn_s;
    logic [NUM_STAGES-1:0] stage_run, stage_done;
    seq_state_e            state;

    pwr_sync2 #(.RST_VAL(1'b0)) u_pg_sync (
        .clk(clk), .rst_n(por_n), .async_in(pg_all_in), .sync_out(pg_s));

    pwr_sync2 #(.RST_VAL(1'b0)) u_btn_sync (
        .clk(clk), .rst_n(por_n), .async_in(btn_rst_n), .sync_out(btn_s));

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_tmr
        pwr_stage_timer #(.CYCLES(STAGE_CYCLES)) u_tmr (
            .clk(clk), .rst_n(por_n), .run(stage_run[g]), .done(stage_done[g]));
    end

    pwr_seq_fsm u_fsm (
        .clk(clk), .rst_n(por_n), .pg_ok(pg_s),
        .stage_done(stage_done), .stage_run(stage_run), .state(state));

    assign rail_en   = rails_of(state);
    assign mod_pgood = (state == ST_READY);
    assign dev_rst_n = mod_pgood && btn_s;
    assign noseq     = btn_s;

    // R5
    rails_grow_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rail_en != '0) |=> (((rail_en & $past(rail_en)) == $past(rail_en)) || (rail_en == '0)));

    // R6
    pgood_rails_chk: assert property (@(posedge clk) disable iff (!por_n)
        mod_pgood |-> (&rail_en));

    // R11
    rst_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !mod_pgood |-> !dev_rst_n);
endmodule

// File: tb/pwr_seq_top_bench.sv
module pwr_seq_top_bench;
    localparam int CLK_HZ   = 20000;
    localparam int STAGE_MS = 1;
    localparam int N        = (CLK_HZ / 1000) * STAGE_MS;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pg = 1'b0;
    logic       btn = 1'b1;
    logic [5:0] rail_en;
    logic       mod_pgood, dev_rst_n, noseq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwr_seq_top #(.CLK_HZ(CLK_HZ), .STAGE_MS(STAGE_MS)) u_pwr_seq_top (
        .clk(clk), .por_n(por_n), .pg_all_in(pg), .btn_rst_n(btn),
        .rail_en(rail_en), .mod_pgood(mod_pgood), .dev_rst_n(dev_rst_n), .noseq(noseq));

    // reference model of the requirements
    int   ecnt = 0;
    int   fault_age = 0;
    logic mfault = 0;
    logic pg1 = 0, pg2 = 0, b1 = 0, b2 = 0;

    always @(posedge clk) begin
        if (!por_n) begin
            ecnt <= 0; mfault <= 0; fault_age <= 0;
            pg1 <= 0; pg2 <= 0; b1 <= 0; b2 <= 0;
        end else begin
            pg1 <= pg; pg2 <= pg1; b1 <= btn; b2 <= b1;
            if (!mfault && ecnt >= 3*N + 1 && !pg2) mfault <= 1;
            if (ecnt < 1000000) ecnt <= ecnt + 1;
            if (mfault) fault_age <= fault_age + 1;
        end
    end

    function automatic logic [5:0] exp_rails(int e, logic f);
        if (f || e == 0) return 6'h00;
        if (e <= N)      return 6'h01;
        if (e <= 2*N)    return 6'h0F;
        return 6'h3F;
    endfunction

    function automatic string rail_tag(int e, logic f, int age, logic rst);
        if (rst)       return "R1";
        if (f)         return (age > 3) ? "R8" : "R7";
        if (e == 1)    return "R1";
        if (e == N+1)  return "R12";
        if (e <= N)    return "R2";
        if (e <= 2*N)  return "R3";
        if (e <= 3*N)  return "R4";
        return "R6";
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    logic [5:0] prev_rails = 0;
    logic       quiet_pg = 0;   // current run held pg low throughout the stages

    always @(posedge clk) begin
        #5;
        begin
            logic [5:0] er;
            logic       ep;
            er = exp_rails(ecnt, mfault);
            ep = !mfault && ecnt >= 3*N + 1 && por_n;
            chk(rail_tag(ecnt, mfault, fault_age, !por_n), int'(rail_en), int'(er));
            chk("R6", int'(mod_pgood), int'(ep));
            chk("R11", int'(dev_rst_n), int'(ep && b2));
            chk("R10", int'(noseq), int'(b2));
            if (por_n && !mfault && ecnt > 1)
                chk("R5", int'((rail_en & prev_rails) == prev_rails), 1);
            if (quiet_pg && por_n && ecnt == 3*N)
                chk("R9", int'(rail_en), 6'h3F);
            prev_rails = rail_en;
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <50000 cycles", wd);
            summary();
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd4711);
        for (int run = 0; run < 8; run++) begin
            @(negedge clk);
            por_n = 0; pg = 0; btn = 1;
            quiet_pg = (run == 0);
            tick(3);
            por_n = 1;
            // stages: power-good pattern varies per run and must be ignored (R9)
            for (int c = 0; c < 3*N - 3; c++) begin
                if (run == 0)      pg = 0;
                else if (run == 1) pg = 1;
                else               pg = 1'($urandom);
                tick(1);
            end
            pg = 1;
            // ready: random button activity, random length
            begin
                int len;
                len = (run == 2) ? 4 : int'($urandom_range(8, 40));
                for (int c = 0; c < len; c++) begin
                    btn = ($urandom_range(0, 3) != 0);
                    tick(1);
                end
            end
            // drop power-good (single-cycle glitch on odd runs)
            pg = 0;
            tick(1);
            if (run % 2 == 1) pg = 1;
            tick(14);
            // restore: lockout must hold (R8)
            pg = 1;
            btn = 1;
            tick(10);
        end
        tick(2);
        summary();
    end
endmodule